// File: doc/BRIEF.md
# EDH Field CRC Engine

This block runs two 16-bit checkwords over a stream of 10-bit video words, one for the active picture region and one for the full field. Both run at the same time and are restarted every field. External timing logic marks where each region begins and ends with single-cycle start and stop strobes. When a region ends, its checkword is held and is available both as a plain 16-bit value and as three formatted packet words ready for insertion into an outgoing error data packet.

In receive mode the block also watches the stream for an incoming error data packet, extracts the checkwords and their valid bits from it, and compares them with the held local checkwords. It reports a valid indication and a mismatch flag for each region. In transmit mode those indications are held clear. A small encoder turns six user bits into a reserved-word value with parity protection.

Top module: `edh_crc_engine`

## Requirements
- R1: Before entering the checkword generator, every input word in the range 0x3FC to 0x3FF is replaced by 0x3FF. Other words pass unchanged.
- R2: Each checkword uses the polynomial x^16 + x^12 + x^5 + 1, starts from zero at the region's first word and takes the 10 bits of each word LSB first. For each bit, the feedback is bit 15 XOR the data bit; the register shifts left and, when the feedback is 1, bits 0, 5 and 12 are inverted. The region covers every word from the one presented with start through the one presented with stop, both included. The result appears on the region's checkword output on the edge that takes the stop word.
- R3: The active picture region (index 0) and the full field region (index 1) run independently and may overlap. A start restarts only its own region from zero.
- R4: A held checkword changes only on the edge that takes a stop word of its region.
- R5: Each held checkword is offered as three 10-bit words. Word 0 carries bits 5:0 in word bits 7:2. Word 1 carries bits 11:6 in word bits 7:2. Word 2 carries bits 15:12 in word bits 5:2, 0 in bit 6, and a valid bit in bit 7. The valid bit is set once the region has completed at least once since reset. In every word, bits 1:0 are 0, bit 8 makes bits 8:0 even parity, and bit 9 is the inverse of bit 8. Word 0 is at bus bits 9:0 of the output.
- R6: An incoming packet is recognised from the sequence 0x000, 0x3FF, 0x3FF followed by data ID 0x1F4, block number 0x200 and data count 0x110. The next six words are the active picture checkword words and then the full field checkword words, in the R5 layout. A sequence that breaks off leaves the flags unchanged.
- R7: In receive mode, two edges after the last checkword word of a recognised packet, each region's valid output equals the received valid bit. Its mismatch output is 1 only when that bit is set and the received checkword differs from the held one. Both outputs hold until the next recognised packet.
- R8: While transmit mode is selected, all valid and mismatch outputs are cleared on the next edge.
- R9: The reserved-word output encodes six input bits into bits 7:2 with the R5 parity layout (bits 1:0 zero, even parity bit 8, bit 9 inverted), one edge after the input.
- R10: After reset the checkwords are zero, the valid and mismatch outputs are 0 and the reserved word is 0x200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low reset |
| tx_mode_i | input | 1 | 1 selects transmit mode, 0 receive mode |
| din_i | input | 10 | Video word stream |
| ap_start_i | input | 1 | First word of the active picture region |
| ap_stop_i | input | 1 | Last word of the active picture region |
| ff_start_i | input | 1 | First word of the full field region |
| ff_stop_i | input | 1 | Last word of the full field region |
| rsv_bits_i | input | 6 | Payload bits for the reserved-word encoder |
| ap_crc_o | output | 16 | Held active picture checkword |
| ff_crc_o | output | 16 | Held full field checkword |
| ap_tx_words_o | output | 30 | Three formatted active picture packet words |
| ff_tx_words_o | output | 30 | Three formatted full field packet words |
| ap_rx_valid_o | output | 1 | Received active picture checkword was marked valid |
| ff_rx_valid_o | output | 1 | Received full field checkword was marked valid |
| ap_mismatch_o | output | 1 | Active picture checkword mismatch |
| ff_mismatch_o | output | 1 | Full field checkword mismatch |
| rsv_word_o | output | 10 | Encoded reserved word |

## Verification
Held checkwords and their formatted words are due on the same edge that takes the stop word. The bench drives each word on a falling edge and reads the outputs at the following falling edge, so the value is read in the very cycle it becomes visible. The comparison flags come one edge later than the parser's capture, which is two edges after the last checkword word. The packet task therefore always adds one trailing idle word before the flags are read. The reserved-word output is read one falling edge after its bits are applied.

// File: rtl/edh_crc_pkg.sv
package edh_crc_pkg;
  localparam int WORD_W    = 10;
  localparam int CRC_W     = 16;
  localparam int NUM_REG   = 2;
  localparam int FIELD_W   = 6;
  localparam int PAY_WORDS = 6;
  localparam int IDX_W     = $clog2(PAY_WORDS);
  localparam logic [CRC_W-1:0]  CRC_POLY   = 16'h1021;
  localparam logic [WORD_W-1:0] RECODE_LO  = 10'h3FC;
  localparam logic [WORD_W-1:0] RECODE_TO  = 10'h3FF;
  localparam logic [WORD_W-1:0] ADF_FIRST  = 10'h000;
  localparam logic [WORD_W-1:0] ADF_REST   = 10'h3FF;
  localparam logic [WORD_W-1:0] PKT_DID    = 10'h1F4;
  localparam logic [WORD_W-1:0] PKT_BLK    = 10'h200;
  localparam logic [WORD_W-1:0] PKT_DC     = 10'h110;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CRC_W-1:0]  crc_t;

  function automatic word_t recode_word(word_t w);
    return (w >= RECODE_LO) ? RECODE_TO : w;
  endfunction

  function automatic crc_t crc_word_step(crc_t c, word_t w);
    crc_t r;
    logic fb;
    r = c;
    for (int b = 0; b < WORD_W; b++) begin
      fb = r[CRC_W-1] ^ w[b];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

  function automatic word_t pack_word(logic [FIELD_W-1:0] f);
    logic [7:0] b;
    logic       p;
    b = {f, 2'b00};
    p = ^b;
    return {~p, p, b};
  endfunction
endpackage

// File: rtl/edh_region_crc.sv
module edh_region_crc
  import edh_crc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t word_i,
  input  logic  start_i,
  input  logic  stop_i,
  output crc_t  crc_o,
  output logic  crc_vld_o
);
  crc_t acc_q;
  logic run_q;
  logic take;
  crc_t seed;
  crc_t nxt;

  assign take = start_i | run_q;
  assign seed = start_i ? '0 : acc_q;
  assign nxt  = crc_word_step(seed, word_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      run_q     <= 1'b0;
      crc_o     <= '0;
      crc_vld_o <= 1'b0;
    end else begin
      if (take) acc_q <= nxt;
      if (stop_i)       run_q <= 1'b0;
      else if (start_i) run_q <= 1'b1;
      if (stop_i && take) begin
        crc_o     <= nxt;
        crc_vld_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/edh_pkt_parser.sv
module edh_pkt_parser
  import edh_crc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  word_t                        din_i,
  output logic [NUM_REG-1:0][CRC_W-1:0] rx_crc_o,
  output logic [NUM_REG-1:0]           rx_vld_o,
  output logic                         done_o
);
  typedef enum logic [1:0] {P_IDLE, P_BLK, P_CNT, P_PAY} pstate_t;
  pstate_t     st_q;
  word_t       h0_q, h1_q, h2_q;
  logic [IDX_W-1:0] idx_q;
  logic        adf_hit;

  assign adf_hit = (h2_q == ADF_FIRST) && (h1_q == ADF_REST) && (h0_q == ADF_REST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= P_IDLE;
      h0_q     <= '0;
      h1_q     <= '0;
      h2_q     <= '0;
      idx_q    <= '0;
      rx_crc_o <= '0;
      rx_vld_o <= '0;
      done_o   <= 1'b0;
    end else begin
      h0_q   <= din_i;
      h1_q   <= h0_q;
      h2_q   <= h1_q;
      done_o <= 1'b0;
      unique case (st_q)
        P_IDLE: if (adf_hit && din_i == PKT_DID) st_q <= P_BLK;
        P_BLK:  st_q <= (din_i == PKT_BLK) ? P_CNT : P_IDLE;
        P_CNT: begin
          st_q  <= (din_i == PKT_DC) ? P_PAY : P_IDLE;
          idx_q <= '0;
        end
        P_PAY: begin
          case (idx_q)
            3'd0: rx_crc_o[0][5:0]   <= din_i[7:2];
            3'd1: rx_crc_o[0][11:6]  <= din_i[7:2];
            3'd2: begin
              rx_crc_o[0][15:12] <= din_i[5:2];
              rx_vld_o[0]        <= din_i[7];
            end
            3'd3: rx_crc_o[1][5:0]   <= din_i[7:2];
            3'd4: rx_crc_o[1][11:6]  <= din_i[7:2];
            default: begin
              rx_crc_o[1][15:12] <= din_i[5:2];
              rx_vld_o[1]        <= din_i[7];
            end
          endcase
          if (idx_q == IDX_W'(PAY_WORDS - 1)) begin
            st_q   <= P_IDLE;
            done_o <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edh_crc_engine.sv
module edh_crc_engine
  import edh_crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_mode_i,
  input  logic [9:0]  din_i,
  input  logic        ap_start_i,
  input  logic        ap_stop_i,
  input  logic        ff_start_i,
  input  logic        ff_stop_i,
  input  logic [5:0]  rsv_bits_i,
  output logic [15:0] ap_crc_o,
  output logic [15:0] ff_crc_o,
  output logic [29:0] ap_tx_words_o,
  output logic [29:0] ff_tx_words_o,
  output logic        ap_rx_valid_o,
  output logic        ff_rx_valid_o,
  output logic        ap_mismatch_o,
  output logic        ff_mismatch_o,
  output logic [9:0]  rsv_word_o
);
  word_t                         din_rc;
  logic [NUM_REG-1:0]            reg_start, reg_stop;
  logic [NUM_REG-1:0][CRC_W-1:0] calc_crc;
  logic [NUM_REG-1:0]            calc_vld;
  logic [NUM_REG-1:0][CRC_W-1:0] rx_crc;
  logic [NUM_REG-1:0]            rx_vld;
  logic [NUM_REG-1:0][3*WORD_W-1:0] tx_words;
  logic [NUM_REG-1:0]            flag_vld_q, flag_mis_q;
  logic                          pkt_done;

  assign din_rc    = recode_word(din_i);
  assign reg_start = {ff_start_i, ap_start_i};
  assign reg_stop  = {ff_stop_i,  ap_stop_i};

  edh_pkt_parser u_parser (
    .clk      (clk),
    .rst_n    (rst_n),
    .din_i    (din_i),
    .rx_crc_o (rx_crc),
    .rx_vld_o (rx_vld),
    .done_o   (pkt_done)
  );

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    edh_region_crc u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_i    (din_rc),
      .start_i   (reg_start[r]),
      .stop_i    (reg_stop[r]),
      .crc_o     (calc_crc[r]),
      .crc_vld_o (calc_vld[r])
    );

    assign tx_words[r] = {pack_word({calc_vld[r], 1'b0, calc_crc[r][15:12]}),
                          pack_word(calc_crc[r][11:6]),
                          pack_word(calc_crc[r][5:0])};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_vld_q[r] <= 1'b0;
        flag_mis_q[r] <= 1'b0;
      end else if (tx_mode_i) begin
        flag_vld_q[r] <= 1'b0;
        flag_mis_q[r] <= 1'b0;
      end else if (pkt_done) begin
        flag_vld_q[r] <= rx_vld[r];
        flag_mis_q[r] <= rx_vld[r] && (rx_crc[r] != calc_crc[r]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsv_word_o <= pack_word('0);
    else        rsv_word_o <= pack_word(rsv_bits_i);
  end

  assign ap_crc_o      = calc_crc[0];
  assign ff_crc_o      = calc_crc[1];
  assign ap_tx_words_o = tx_words[0];
  assign ff_tx_words_o = tx_words[1];
  assign ap_rx_valid_o = flag_vld_q[0];
  assign ff_rx_valid_o = flag_vld_q[1];
  assign ap_mismatch_o = flag_mis_q[0];
  assign ff_mismatch_o = flag_mis_q[1];
endmodule

// File: rtl/edh_crc_engine_chk.sv
module edh_crc_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_mode_i,
  input logic        ap_stop_i,
  input logic        ff_stop_i,
  input logic        pkt_done,
  input logic [15:0] ap_crc_o,
  input logic [15:0] ff_crc_o,
  input logic [29:0] ap_tx_words_o,
  input logic        ap_rx_valid_o,
  input logic        ff_rx_valid_o,
  input logic        ap_mismatch_o,
  input logic        ff_mismatch_o,
  input logic [9:0]  rsv_word_o
);
  assert_ap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ap_stop_i |=> $stable(ap_crc_o));
  assert_ff_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ff_stop_i |=> $stable(ff_crc_o));
  assert_ap_mis_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ap_mismatch_o |-> ap_rx_valid_o);
  assert_ff_mis_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ff_mismatch_o |-> ff_rx_valid_o);
  assert_flags_only_on_packet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_done && !tx_mode_i) |=> ($stable(ap_mismatch_o) && $stable(ap_rx_valid_o)));
  assert_tx_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode_i |=> (!ap_mismatch_o && !ff_mismatch_o && !ap_rx_valid_o && !ff_rx_valid_o));
  assert_rsv_layout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((^rsv_word_o[8:0]) == 1'b0) && (rsv_word_o[9] != rsv_word_o[8]) && (rsv_word_o[1:0] == 2'b00));
  assert_tx_word_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_tx_words_o[29] != ap_tx_words_o[28]) && (ap_tx_words_o[26] == 1'b0));
endmodule

bind edh_crc_engine edh_crc_engine_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_mode_i     (tx_mode_i),
  .ap_stop_i     (ap_stop_i),
  .ff_stop_i     (ff_stop_i),
  .pkt_done      (pkt_done),
  .ap_crc_o      (ap_crc_o),
  .ff_crc_o      (ff_crc_o),
  .ap_tx_words_o (ap_tx_words_o),
  .ap_rx_valid_o (ap_rx_valid_o),
  .ff_rx_valid_o (ff_rx_valid_o),
  .ap_mismatch_o (ap_mismatch_o),
  .ff_mismatch_o (ff_mismatch_o),
  .rsv_word_o    (rsv_word_o)
);

// File: tb/edh_crc_engine_tb.sv
module edh_crc_engine_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_mode_i = 1'b0;
  logic [9:0]  din_i = '0;
  logic        ap_start_i = 1'b0, ap_stop_i = 1'b0, ff_start_i = 1'b0, ff_stop_i = 1'b0;
  logic [5:0]  rsv_bits_i = '0;
  logic [15:0] ap_crc_o, ff_crc_o;
  logic [29:0] ap_tx_words_o, ff_tx_words_o;
  logic        ap_rx_valid_o, ff_rx_valid_o, ap_mismatch_o, ff_mismatch_o;
  logic [9:0]  rsv_word_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edh_crc_engine dut_i (.*);

  // Bench model: explicit tap form of the x^16+x^12+x^5+1 register.
  function automatic logic [15:0] m_step(logic [15:0] c, logic [9:0] w);
    logic [9:0]  v;
    logic [15:0] n;
    logic        fb;
    v = (w >= 10'h3FC) ? 10'h3FF : w;
    for (int b = 0; b < 10; b++) begin
      fb = c[15] ^ v[b];
      for (int k = 15; k > 0; k--) n[k] = c[k-1];
      n[0]  = fb;
      n[5]  = c[4] ^ fb;
      n[12] = c[11] ^ fb;
      c = n;
    end
    return c;
  endfunction

  function automatic logic [9:0] m_fmt(logic [5:0] f);
    int ones = 0;
    for (int k = 0; k < 6; k++) ones += f[k];
    return {~ones[0], ones[0], f, 2'b00};
  endfunction

  function automatic logic [29:0] m_tx(logic [15:0] c, logic v);
    return {m_fmt({v, 1'b0, c[15:12]}), m_fmt(c[11:6]), m_fmt(c[5:0])};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [9:0] w, logic as = 0, logic ap = 0, logic fs = 0, logic fp = 0);
    din_i = w; ap_start_i = as; ap_stop_i = ap; ff_start_i = fs; ff_stop_i = fp;
    @(negedge clk);
    ap_start_i = 0; ap_stop_i = 0; ff_start_i = 0; ff_stop_i = 0;
  endtask

  task automatic send_pkt(logic [9:0] dc, logic [15:0] ac, logic av, logic [15:0] fc, logic fv);
    logic [29:0] a, f;
    a = m_tx(ac, av);
    f = m_tx(fc, fv);
    send(10'h000); send(10'h3FF); send(10'h3FF);
    send(10'h1F4); send(10'h200); send(dc);
    send(a[9:0]); send(a[19:10]); send(a[29:20]);
    send(f[9:0]); send(f[19:10]); send(f[29:20]);
    send(10'h040); // flags latch on this edge
  endtask

  logic [15:0] ap_ref, ff_ref;

  task automatic t_reset;
    chk("R10 ap_crc", ap_crc_o, 0);
    chk("R10 ff_crc", ff_crc_o, 0);
    chk("R10 flags", {ap_rx_valid_o, ff_rx_valid_o, ap_mismatch_o, ff_mismatch_o}, 0);
    chk("R10 rsv", rsv_word_o, 10'h200);
  endtask

  task automatic t_overlap;
    logic [15:0] a = 0, f = 0;
    for (int i = 0; i < 8; i++) begin
      logic [9:0] w = 10'(i * 37 + 5);
      f = m_step(f, w);
      if (i >= 2 && i <= 5) a = m_step(a, w);
      send(w, i == 2, i == 5, i == 0, i == 7);
      if (i == 5) chk("R2 ap result on stop edge", ap_crc_o, a);
    end
    chk("R3 ap independent", ap_crc_o, a);
    chk("R3 ff overlapping", ff_crc_o, f);
    ap_ref = a; ff_ref = f;
  endtask

  task automatic t_recode;
    logic [15:0] first, model = 0;
    send(10'h3FC, 1); send(10'h3FD); send(10'h3FE); send(10'h012, 0, 1);
    first = ap_crc_o;
    send(10'h3FF, 1); send(10'h3FF); send(10'h3FF); send(10'h012, 0, 1);
    chk("R1 recoded equals 3FF", ap_crc_o, first);
    model = m_step(m_step(m_step(m_step(0, 10'h3FF), 10'h3FF), 10'h3FF), 10'h012);
    chk("R1 recoded model", ap_crc_o, model);
  endtask

  task automatic t_hold;
    logic [15:0] old, model = 0;
    old = ap_crc_o;
    for (int i = 0; i < 4; i++) begin
      send(10'(100 + i), i == 0);
      model = m_step(model, 10'(100 + i));
    end
    chk("R4 held during run", ap_crc_o, old);
    send(10'h155, 0, 1);
    model = m_step(model, 10'h155);
    chk("R3 restart from zero", ap_crc_o, model);
    send(10'h2AA, 1, 1);
    chk("R2 single word region", ap_crc_o, m_step(0, 10'h2AA));
  endtask

  task automatic t_format;
    t_overlap();
    chk("R5 ap words", ap_tx_words_o, m_tx(ap_ref, 1));
    chk("R5 ff words", ff_tx_words_o, m_tx(ff_ref, 1));
  endtask

  task automatic t_rx;
    send_pkt(10'h110, ap_ref, 1, ff_ref, 1);
    chk("R7 match valid", {ap_rx_valid_o, ff_rx_valid_o}, 2'b11);
    chk("R7 match no mismatch", {ap_mismatch_o, ff_mismatch_o}, 2'b00);
    send_pkt(10'h110, ap_ref ^ 16'h0100, 1, ff_ref, 1);
    chk("R6 ap mismatch", {ap_mismatch_o, ff_mismatch_o}, 2'b10);
    send_pkt(10'h111, ap_ref, 1, ff_ref ^ 16'h8000, 1);
    chk("R6 bad count ignored", {ap_rx_valid_o, ff_rx_valid_o, ap_mismatch_o, ff_mismatch_o}, 4'b1110);
    send_pkt(10'h110, ap_ref ^ 16'h0001, 0, ff_ref ^ 16'h4000, 1);
    chk("R7 invalid ap no flag", {ap_rx_valid_o, ap_mismatch_o}, 2'b00);
    chk("R7 ff mismatch", {ff_rx_valid_o, ff_mismatch_o}, 2'b11);
  endtask

  task automatic t_tx;
    tx_mode_i = 1;
    send_pkt(10'h110, ap_ref ^ 16'h0F0F, 1, ff_ref ^ 16'h1, 1);
    chk("R8 tx clears flags", {ap_rx_valid_o, ff_rx_valid_o, ap_mismatch_o, ff_mismatch_o}, 0);
    tx_mode_i = 0;
  endtask

  task automatic t_rsv;
    logic [5:0] vals [3] = '{6'h00, 6'h3F, 6'h15};
    foreach (vals[i]) begin
      rsv_bits_i = vals[i];
      @(negedge clk);
      chk("R9 reserved word", rsv_word_o, m_fmt(vals[i]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_overlap();
    t_recode();
    t_hold();
    t_format();
    t_rx();
    t_tx();
    t_rsv();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule